// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches bytes between time slots of sixteen framed serial streams. Each input stream is shifted in MSB first and turned into bytes. Every completed channel byte is stored in a two-bank data memory, indexed by stream and channel. For every output stream and channel, a connection memory word says where that output slot gets its byte. It can take any input stream and channel, or a fixed byte held in the word itself. The word also says whether the slot drives its line at all, and whether the byte must keep frame integrity or should arrive with the least latency. The selected bytes are shifted out MSB first.

All streams run at one common line rate. A 2-bit rate field sets the number of 8-bit channels per frame. The serial clock is always twice the bit rate, so one bit lasts two clocks at every rate. An active-low frame pulse realigns the channel and bit counters.

A host programs the rate field and the connection words through a write-only register port. A global drive-enable input can silence every output line at once.

Top module: `tsi_switch`

## Requirements
- R1: While reset is low, and after its release until a connection word enables a slot, every bit of `sout_oe` is 0. Reset clears the counters, the rate field, the bank select and all connection words.
- R2: A host write with `host_addr[11]`=1 loads the rate field from `host_wdata[1:0]`. The value 0 gives 32 channels per frame, 1 gives 64, and 2 or 3 gives 128. A frame lasts channels×16 clocks, and the counters wrap to channel 0 at its end without a frame pulse.
- R3: When `fp_n` is sampled low at a rising clock edge, the next cycle is the first clock of channel 0, bit 7. Every bit is held for two clocks, the input is captured on the second of them, and bytes travel MSB first on both sides.
- R4: A host write with `host_addr[11]`=0 stores `host_wdata` as the connection word of output stream `host_addr[10:7]`, channel `host_addr[6:0]`. In that word, bits [10:7] give the source stream and bits [6:0] the source channel. Any source can feed any output slot, and one source can feed several slots at once.
- R5: When bit 13 of the word is 1 (constant delay), output channel k of frame N+1 carries the source byte received in frame N, whatever the order of k and the source channel.
- R6: When bit 13 of the word is 0 (variable delay), the output carries the source byte from the same frame if the source channel is lower than k. Otherwise it carries the byte from the previous frame.
- R7: When bit 15 of the word is 1 (message mode), the slot transmits bits [7:0] of the word instead of switched data.
- R8: Bit 14 of the word enables the slot's driver. When it is 0, `sout_oe` of that stream is low for all 16 clocks of the slot, and it does not change within a slot.
- R9: While `drive_en` is low, all bits of `sout_oe` are low, whatever the connection words say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse |
| drive_en | input | 1 | Global output enable; low silences all lines |
| sin | input | 16 | Serial input streams |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Bit 11 selects the rate field; otherwise output stream and channel |
| host_wdata | input | 16 | Host write data |
| sout | output | 16 | Serial output data |
| sout_oe | output | 16 | Per-stream line driver enable |

## Verification
On every cycle, the assertions check the following. The enables are quiet after reset. The counters land on channel 0, bit 7 after a frame pulse and at the natural end of a frame. The bank select flips at each frame pulse. Output data holds over both clocks of a bit, and the driver enables stay steady within a slot.

Only the bench's scenarios can show which frame a routed byte comes from, under the constant and the variable delay rules. They also show multicast, message bytes, and the channel count at each rate setting. This includes the corner where the last input channel of a frame feeds output channel 0 of the next frame.

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch #(
  parameter int NSTR = 16,
  parameter int CHW = 7,
  localparam int SW = $clog2(NSTR),
  localparam int AW = SW + CHW + 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_n,
  input  logic            drive_en,
  input  logic [NSTR-1:0] sin,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [15:0]     host_wdata,
  output logic [NSTR-1:0] sout,
  output logic [NSTR-1:0] sout_oe
);
  localparam int CW = CHW + 4;
  localparam int CMN = NSTR << CHW;
  localparam int MSG_B = 15;
  localparam int OE_B = 14;
  localparam int CD_B = 13;

  logic [CW-1:0]   cnt;
  logic [1:0]      rate;
  logic            wbank;
  logic [CHW:0]    nch;
  logic [15:0]     cmem [CMN];
  logic [7:0]      dmem [2*CMN];
  logic [7:0]      ish [NSTR];
  logic [7:0]      ibyte [NSTR];
  logic [7:0]      oshr [NSTR];
  logic [7:0]      ld_byte [NSTR];
  logic [NSTR-1:0] oen, ld_oe;

  wire [CHW-1:0] ch = cnt[CW-1:4];
  wire last = &cnt[3:0];
  wire load = !fp_n || last;
  wire fend = !fp_n || (last && ({1'b0, ch} >= nch - (CHW+1)'(1)));
  wire [CHW-1:0] nxt_ch = fend ? '0 : ch + CHW'(1);
  wire nbank = fend ? ~wbank : wbank;

  always_comb
    nch = (CHW+1)'(1) << (CHW - 2 + ((rate == 2'd0) ? 0 : (rate == 2'd1) ? 1 : 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      wbank <= 1'b0;
      rate <= 2'd0;
      oen <= '0;
      for (int j = 0; j < NSTR; j++) oshr[j] <= '0;
      for (int i = 0; i < CMN; i++) cmem[i] <= '0;
    end else begin
      cnt <= fend ? '0 : cnt + CW'(1);
      if (fend) wbank <= ~wbank;
      if (host_we && host_addr[AW-1]) rate <= host_wdata[1:0];
      if (host_we && !host_addr[AW-1]) cmem[host_addr[AW-2:0]] <= host_wdata;
      for (int j = 0; j < NSTR; j++) begin
        if (load) begin
          oshr[j] <= ld_byte[j];
          oen[j] <= ld_oe[j];
        end else if (cnt[0]) begin
          oshr[j] <= {oshr[j][6:0], 1'b0};
        end
      end
    end
  end

  always_comb
    for (int i = 0; i < NSTR; i++) ibyte[i] = {ish[i][6:0], sin[i]};

  always_ff @(posedge clk)
    for (int i = 0; i < NSTR; i++) begin
      if (cnt[0]) ish[i] <= ibyte[i];
      if (last) dmem[{wbank, SW'(i), ch}] <= ibyte[i];
    end

  always_comb begin
    logic [15:0]    cw;
    logic [SW-1:0]  sst;
    logic [CHW-1:0] sch;
    logic           rb;
    logic [7:0]     d;
    for (int j = 0; j < NSTR; j++) begin
      cw  = cmem[{SW'(j), nxt_ch}];
      sst = cw[CHW +: SW];
      sch = cw[CHW-1:0];
      rb  = (cw[CD_B] || !(sch < nxt_ch)) ? ~nbank : nbank;
      d   = (last && (rb == wbank) && (sch == ch)) ? ibyte[sst] : dmem[{rb, sst, sch}];
      ld_byte[j] = cw[MSG_B] ? cw[7:0] : d;
      ld_oe[j]   = cw[OE_B];
    end
  end

  always_comb
    for (int j = 0; j < NSTR; j++) sout[j] = oshr[j][7];

  assign sout_oe = oen & {NSTR{drive_en}};
endmodule

// File: rtl/tsi_switch_chk.sv
`timescale 1ns/1ps
module tsi_switch_chk #(
  parameter int NSTR = 16,
  parameter int CW = 11,
  parameter int CHW = 7
)(
  input logic            clk,
  input logic            rst_n,
  input logic            fp_n,
  input logic            drive_en,
  input logic [NSTR-1:0] sout,
  input logic [NSTR-1:0] sout_oe,
  input logic [CW-1:0]   cnt,
  input logic            wbank,
  input logic [CHW:0]    nch
);
  wire last = &cnt[3:0];
  wire [CHW:0] chx = {1'b0, cnt[CW-1:4]};

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sout_oe == '0);

  // R3
  fp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> cnt == '0);

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && chx == nch - (CHW+1)'(1)) |=> cnt == '0);

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] |-> $stable(sout));

  // R8
  slot_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en) && cnt[3:0] != 4'd0) |-> $stable(sout_oe));

  // R5
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> wbank != $past(wbank));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .CW(CW), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .drive_en(drive_en),
  .sout(sout), .sout_oe(sout_oe), .cnt(cnt), .wbank(wbank), .nch(nch)
);

// File: tb/tsi_switch_tb.sv
`timescale 1ns/1ps
module tsi_switch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_n = 1'b1;
  logic        drive_en = 1'b1;
  logic [15:0] sin = '0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] sout, sout_oe;

  int total = 0;
  int bad = 0;

  logic [7:0] cap [3][16][128];
  logic [4:0] oecnt [3][16][128];

  always #2 clk = ~clk;

  tsi_switch dut_i (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .drive_en(drive_en), .sin(sin),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .sout(sout), .sout_oe(sout_oe)
  );

  function automatic logic [7:0] inb(input int f, input int s, input int c);
    return 8'(f * 97 + s * 13 + c * 7 + 3);
  endfunction

  function automatic logic [15:0] w_route(input int s, input int c, input bit cd, input bit oe);
    return {1'b0, oe, cd, 2'b00, 4'(s), 7'(c)};
  endfunction

  function automatic logic [15:0] w_msg(input logic [7:0] b, input bit oe);
    return {1'b1, oe, 6'b0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic map(input int o, input int k, input logic [15:0] w);
    wr({1'b0, 4'(o), 7'(k)}, w);
  endtask

  task automatic set_rate(input logic [1:0] r);
    wr(12'h800, {14'd0, r});
  endtask

  task automatic run_frames(input int nf, input int nc);
    int fl;
    fl = nc * 16;
    @(negedge clk);
    fp_n = 1'b0; sin = '0;
    for (int f = 0; f < nf; f++)
      for (int c = 0; c < fl; c++) begin
        @(negedge clk);
        for (int s = 0; s < 16; s++) begin
          logic [7:0] b;
          if (c % 2 == 0) cap[f][s][c/16][7 - (c % 16) / 2] = sout[s];
          if (c % 16 == 0) oecnt[f][s][c/16] = '0;
          oecnt[f][s][c/16] = oecnt[f][s][c/16] + 5'(sout_oe[s]);
          b = inb(f, s, c / 16);
          sin[s] = b[7 - (c % 16) / 2];
        end
        fp_n = (c == fl - 1) ? 1'b0 : 1'b1;
      end
    @(negedge clk);
    fp_n = 1'b1; sin = '0;
  endtask

  task automatic expect_slot(input int f, input int o, input int k, input logic [7:0] ev, input string req);
    chk(cap[f][o][k] == ev, req, int'(cap[f][o][k]), int'(ev));
    chk(oecnt[f][o][k] == 5'd16, {req, " enable"}, int'(oecnt[f][o][k]), 16);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sout_oe == '0, "R1 enables in reset", int'(sout_oe), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(sout_oe == '0, "R1 enables after reset", int'(sout_oe), 0);
    chk(sout == '0, "R1 data after reset", int'(sout), 0);
  endtask

  task automatic t_const;
    set_rate(2'd0);
    map(0, 0, w_route(3, 31, 1, 1));
    map(5, 10, w_route(3, 31, 1, 1));
    map(15, 31, w_route(0, 0, 1, 1));
    map(2, 7, w_route(9, 20, 1, 1));
    map(2, 25, w_route(9, 20, 1, 1));
    run_frames(3, 32);
    for (int f = 1; f < 3; f++) begin
      expect_slot(f, 0, 0, inb(f-1, 3, 31), "R5 last channel to channel 0");
      expect_slot(f, 5, 10, inb(f-1, 3, 31), "R4 multicast");
      expect_slot(f, 15, 31, inb(f-1, 0, 0), "R5 first to last");
      expect_slot(f, 2, 7, inb(f-1, 9, 20), "R5 later source");
      expect_slot(f, 2, 25, inb(f-1, 9, 20), "R5 earlier source");
    end
  endtask

  task automatic t_var;
    map(1, 5, w_route(4, 2, 0, 1));
    map(1, 2, w_route(4, 2, 0, 1));
    map(1, 3, w_route(4, 2, 0, 1));
    map(1, 0, w_route(4, 31, 0, 1));
    map(1, 31, w_route(4, 30, 0, 1));
    run_frames(3, 32);
    for (int f = 1; f < 3; f++) begin
      expect_slot(f, 1, 5, inb(f, 4, 2), "R6 same frame");
      expect_slot(f, 1, 2, inb(f-1, 4, 2), "R6 equal channel");
      expect_slot(f, 1, 3, inb(f, 4, 2), "R6 adjacent channel");
      expect_slot(f, 1, 0, inb(f-1, 4, 31), "R6 channel 0");
      expect_slot(f, 1, 31, inb(f, 4, 30), "R6 last channel");
    end
  endtask

  task automatic t_msg;
    map(6, 4, w_msg(8'hC4, 1));
    map(6, 5, w_msg(8'h3A, 1));
    run_frames(3, 32);
    for (int f = 0; f < 3; f++) begin
      expect_slot(f, 6, 4, 8'hC4, "R7 R3 message byte");
      expect_slot(f, 6, 5, 8'h3A, "R7 message byte");
    end
  endtask

  task automatic t_hiz;
    map(7, 9, w_route(1, 1, 1, 0));
    map(7, 8, w_route(1, 1, 1, 1));
    map(7, 10, w_msg(8'hFF, 0));
    run_frames(2, 32);
    chk(oecnt[1][7][9] == 5'd0, "R8 routed slot off", int'(oecnt[1][7][9]), 0);
    chk(oecnt[1][7][10] == 5'd0, "R8 message slot off", int'(oecnt[1][7][10]), 0);
    expect_slot(1, 7, 8, inb(0, 1, 1), "R8 neighbour slot on");
  endtask

  task automatic t_gdis;
    @(negedge clk);
    drive_en = 1'b0;
    run_frames(2, 32);
    chk(oecnt[1][0][0] == 5'd0, "R9 stream 0", int'(oecnt[1][0][0]), 0);
    chk(oecnt[1][6][4] == 5'd0, "R9 stream 6", int'(oecnt[1][6][4]), 0);
    chk(oecnt[1][7][8] == 5'd0, "R9 stream 7", int'(oecnt[1][7][8]), 0);
    @(negedge clk);
    drive_en = 1'b1;
    run_frames(2, 32);
    expect_slot(1, 6, 4, 8'hC4, "R9 enable restored");
  endtask

  task automatic t_rate;
    set_rate(2'd2);
    map(3, 127, w_route(11, 100, 1, 1));
    map(3, 0, w_route(11, 127, 1, 1));
    map(3, 64, w_route(11, 5, 0, 1));
    run_frames(3, 128);
    for (int f = 1; f < 3; f++) begin
      expect_slot(f, 3, 127, inb(f-1, 11, 100), "R2 128 channels");
      expect_slot(f, 3, 0, inb(f-1, 11, 127), "R2 R5 channel 127 wrap");
      expect_slot(f, 3, 64, inb(f, 11, 5), "R2 R6 128 channels");
    end
    set_rate(2'd3);
    run_frames(2, 128);
    expect_slot(1, 3, 127, inb(0, 11, 100), "R2 value 3");
    set_rate(2'd1);
    map(8, 63, w_route(2, 40, 0, 1));
    map(8, 0, w_route(2, 63, 1, 1));
    run_frames(2, 64);
    expect_slot(1, 8, 63, inb(1, 2, 40), "R2 64 channels");
    expect_slot(1, 8, 0, inb(0, 2, 63), "R2 64 channel wrap");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    t_const;
    t_var;
    t_msg;
    t_hiz;
    t_gdis;
    t_rate;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #760000;
    total++;
    bad++;
    $display("FAIL watchdog R2 frame timing actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule